// File: doc/BRIEF.md
# Posted Write Burst Buffer Slave

This block is the write-side front end of a bridge between two buses. On the upstream side it acts as a slave. It decodes each address against a configurable set of inclusive ranges, acknowledges write beats in the same cycle, and stores their data in a local word buffer. Each beat carries a sequential-address flag. When the flag is low, the beat is a single transfer: the block keeps its byte enables and word address. When the flag is high, the beat starts or continues a burst: the block counts the stored words and later reports that count as a fixed burst length.

Once a transfer is closed, the block raises a request towards a downstream burst master. The downstream master is modelled here as a request/done handshake, and it reads the buffer through a small index port. While the request is pending, every upstream access is answered with a retry. Any error the downstream side reports is dropped, because the write was already posted.

A burst closes in three cases: the upstream master stops presenting sequential beats, the buffer holds its maximum number of words, or the next beat lies above the upper bound of the range in which the burst started.

Top module: `wr_post_buf`

## Requirements
- R1: With no request pending, an access is acknowledged only if its byte address satisfies lo <= addr <= hi for at least one configured range. An access outside every range gets neither acknowledge nor retry.
- R2: A beat with `m_seq` low inside a range is acknowledged. Its data goes to buffer index 0. One cycle later `dn_req` is high, with `dn_burst`=0, `dn_be` equal to the beat's byte enables, `dn_addr` equal to `m_addr[31:2]` and `dn_len`=1.
- R3: An aligned beat with `m_seq` high inside a range starts a burst, and each following sequential beat is acknowledged and stored at the next buffer index. The burst closes on the first cycle without a sequential beat. The request then shows `dn_burst`=1, `dn_len` equal to the number of acknowledged words, `dn_addr` equal to the first beat's `m_addr[31:2]`, and `dn_be`=4'hF whatever byte enables were driven.
- R4: A burst whose first beat has `m_addr[1:0]` not equal to 2'b00 is not acknowledged and raises no request.
- R5: When the 16th word of a burst is acknowledged, the burst closes at once with `dn_len`=16. A further beat of that burst gets a retry and no acknowledge.
- R6: A burst beat whose address is above the upper bound of the range where the burst started is not acknowledged, even when that address lies in an adjacent range. The burst closes and carries only the words already accepted.
- R7: While `dn_req` is high, any access with `m_sel` high gets `s_retry` and no `s_ack`, and the buffer contents stay unchanged.
- R8: `dn_req` and its attributes stay steady until a cycle with `dn_done` high. One cycle later `dn_req` is low and new accesses are accepted. The value of `dn_err` has no effect.
- R9: A burst of exactly one word is reported with `dn_burst`=1 and `dn_len`=1, and not as a single transfer.
- R10: After reset, `dn_req` is low, `dn_len` is 0 and every buffer word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| m_sel | input | 1 | Upstream write beat present |
| m_seq | input | 1 | Sequential-address flag: 1 = burst beat, 0 = single |
| m_addr | input | 32 | Byte address of the beat |
| m_be | input | 4 | Byte enables of the beat |
| m_wdata | input | 32 | Write data of the beat |
| s_ack | output | 1 | Beat accepted (combinational, same cycle) |
| s_retry | output | 1 | Access refused, retry later |
| dn_req | output | 1 | Downstream write request pending |
| dn_burst | output | 1 | 1 = fixed-length burst, 0 = single with byte enables |
| dn_addr | output | 30 | Word address of the first word |
| dn_be | output | 4 | Byte enables for the downstream transfer |
| dn_len | output | 5 | Number of buffered words (1 to 16) |
| dn_done | input | 1 | Downstream completion pulse |
| dn_err | input | 1 | Downstream error status, discarded |
| rd_idx | input | 4 | Buffer read index |
| rd_data | output | 32 | Buffer word at `rd_idx` |

## Verification
The downstream completion pulse can arrive in the same cycle as a new upstream access. The bench forces this collision by raising `m_sel` together with `dn_done`. It expects a retry in that cycle and an idle, accepting slave in the next one. The second collision is the buffer limit against the range bound. Bursts start at random word offsets and run for lengths of up to 20 words, so some of them reach the 16th word and others hit the range end first. For every burst the bench model works out which of the two cuts the burst, and it compares the acknowledge of each beat and the final `dn_len` with that result.

// File: rtl/wr_post_buf.sv
module wr_post_buf #(
  parameter int NRNG  = 2,
  parameter int DEPTH = 16,
  parameter logic [NRNG*32-1:0] RNG_LO = {32'h1000_0100, 32'h1000_0000},
  parameter logic [NRNG*32-1:0] RNG_HI = {32'h1000_01FF, 32'h1000_00FF}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         m_sel,
  input  logic                         m_seq,
  input  logic [31:0]                  m_addr,
  input  logic [3:0]                   m_be,
  input  logic [31:0]                  m_wdata,
  output logic                         s_ack,
  output logic                         s_retry,
  output logic                         dn_req,
  output logic                         dn_burst,
  output logic [29:0]                  dn_addr,
  output logic [3:0]                   dn_be,
  output logic [$clog2(DEPTH+1)-1:0]   dn_len,
  input  logic                         dn_done,
  input  logic                         dn_err,
  input  logic [$clog2(DEPTH)-1:0]     rd_idx,
  output logic [31:0]                  rd_data
);
  localparam int CW = $clog2(DEPTH+1);
  localparam int IW = $clog2(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_POST} st_t;
  st_t st;

  logic [31:0]   mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [31:0]   hi_l;
  logic          hit;
  logic [31:0]   hit_hi;

  always_comb begin
    hit    = 1'b0;
    hit_hi = '0;
    for (int i = 0; i < NRNG; i++)
      if (!hit && m_addr >= RNG_LO[i*32 +: 32] && m_addr <= RNG_HI[i*32 +: 32]) begin
        hit    = 1'b1;
        hit_hi = RNG_HI[i*32 +: 32];
      end
  end

  wire start_ok = (st == S_IDLE) && m_sel && hit && (!m_seq || m_addr[1:0] == 2'b00);
  wire beat_ok  = (st == S_FILL) && m_sel && m_seq && (m_addr <= hi_l);

  assign s_ack   = start_ok | beat_ok;
  assign s_retry = (st == S_POST) && m_sel;
  assign dn_req  = (st == S_POST);
  assign dn_len  = cnt;
  assign rd_data = mem[rd_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cnt      <= '0;
      hi_l     <= '0;
      dn_burst <= 1'b0;
      dn_be    <= '0;
      dn_addr  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (s_ack) mem[cnt[IW-1:0]] <= m_wdata;
      case (st)
        S_IDLE:
          if (start_ok) begin
            cnt     <= CW'(1);
            dn_addr <= m_addr[31:2];
            if (!m_seq) begin
              dn_burst <= 1'b0;
              dn_be    <= m_be;
              st       <= S_POST;
            end else begin
              dn_burst <= 1'b1;
              dn_be    <= 4'hF;
              hi_l     <= hit_hi;
              st       <= S_FILL;
            end
          end
        S_FILL:
          if (beat_ok) begin
            cnt <= cnt + 1'b1;
            if (cnt == CW'(DEPTH-1)) st <= S_POST;
          end else begin
            st <= S_POST;
          end
        default:
          if (dn_done) begin
            st  <= S_IDLE;
            cnt <= '0;
          end
      endcase
    end
  end

  assert_ack_vs_retry_R7: assert property (@(posedge clk) disable iff (rst)
    !(s_ack && s_retry));

  assert_req_held_R8: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_done |=> dn_req && $stable(dn_len) && $stable(dn_addr) && $stable(dn_burst));

  assert_err_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_done && dn_err |=> !dn_req);

  assert_len_bounds_R5: assert property (@(posedge clk) disable iff (rst)
    dn_req |-> dn_len >= CW'(1) && dn_len <= CW'(DEPTH));

  assert_single_len_R2: assert property (@(posedge clk) disable iff (rst)
    dn_req && !dn_burst |-> dn_len == CW'(1));

  assert_burst_be_R3: assert property (@(posedge clk) disable iff (rst)
    dn_req && dn_burst |-> dn_be == 4'hF);

  assert_no_ack_busy_R7: assert property (@(posedge clk) disable iff (rst)
    dn_req && m_sel |-> !s_ack);
endmodule

// File: tb/sim_wr_post_buf.sv
`timescale 1ns/1ps
module sim_wr_post_buf;
  localparam logic [31:0] LO0 = 32'h1000_0000, HI0 = 32'h1000_00FF;
  localparam logic [31:0] LO1 = 32'h1000_0100, HI1 = 32'h1000_01FF;

  logic clk = 0, rst = 1;
  logic m_sel = 0, m_seq = 0, dn_done = 0, dn_err = 0;
  logic [31:0] m_addr = 0, m_wdata = 0;
  logic [3:0]  m_be = 0, rd_idx = 0;
  logic s_ack, s_retry, dn_req, dn_burst;
  logic [29:0] dn_addr;
  logic [3:0]  dn_be;
  logic [4:0]  dn_len;
  logic [31:0] rd_data;

  int nchk = 0, nfail = 0;
  bit done_flag = 0;
  logic [31:0] exp_mem [16];

  always #5 clk = ~clk;

  wr_post_buf #(.NRNG(2), .DEPTH(16), .RNG_LO({LO1, LO0}), .RNG_HI({HI1, HI0})) u0 (
    .clk(clk), .rst(rst), .m_sel(m_sel), .m_seq(m_seq), .m_addr(m_addr), .m_be(m_be),
    .m_wdata(m_wdata), .s_ack(s_ack), .s_retry(s_retry), .dn_req(dn_req),
    .dn_burst(dn_burst), .dn_addr(dn_addr), .dn_be(dn_be), .dn_len(dn_len),
    .dn_done(dn_done), .dn_err(dn_err), .rd_idx(rd_idx), .rd_data(rd_data));

  function automatic bit f_hit(logic [31:0] a);
    return (a >= LO0 && a <= HI0) || (a >= LO1 && a <= HI1);
  endfunction

  function automatic logic [31:0] f_hi(logic [31:0] a);
    return (a >= LO0 && a <= HI0) ? HI0 : HI1;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_buf(int n);
    for (int i = 0; i < n; i++) begin
      rd_idx = 4'(i); #1;
      chk("R3 buffer word", rd_data, exp_mem[i]);
    end
  endtask

  task automatic finish_req(bit collide);
    @(posedge clk); #1;
    m_sel = 1; m_seq = 1'($urandom); m_addr = LO0 + 32'(($urandom % 64) * 4);
    m_wdata = $urandom; rd_idx = 0;
    @(negedge clk);
    chk("R7 retry while busy", {s_retry, s_ack}, 2'b10);
    @(posedge clk); #1;
    m_sel = collide; dn_done = 1; dn_err = 1'($urandom);
    @(negedge clk);
    chk("R7 buffer unchanged", rd_data, exp_mem[0]);
    if (collide) chk("R7 retry on done cycle", {s_retry, s_ack}, 2'b10);
    @(posedge clk); #1;
    dn_done = 0; dn_err = 0; m_sel = 0;
    @(negedge clk);
    chk("R8 request released", dn_req, 1'b0);
  endtask

  task automatic single(logic [31:0] a, logic [3:0] be, logic [31:0] d, bit collide);
    bit ok;
    @(posedge clk); #1;
    m_sel = 1; m_seq = 0; m_addr = a; m_be = be; m_wdata = d;
    @(negedge clk);
    ok = f_hit(a);
    chk("R1 single decode ack", s_ack, ok);
    chk("R1 no retry when idle", s_retry, 1'b0);
    @(posedge clk); #1;
    m_sel = 0;
    @(negedge clk);
    chk("R2 request raised", dn_req, ok);
    if (ok) begin
      exp_mem[0] = d;
      chk("R2 single kind", dn_burst, 1'b0);
      chk("R2 byte enables", dn_be, be);
      chk("R2 word address", dn_addr, a[31:2]);
      chk("R2 length", dn_len, 5'd1);
      rd_idx = 0; #1;
      chk("R2 buffer data", rd_data, d);
      finish_req(collide);
    end
  endtask

  task automatic burst(logic [31:0] a0, int n, bit collide);
    int cnt = 0;
    logic [31:0] hi = 0, a;
    bit exp_ack;
    for (int k = 0; k < n; k++) begin
      @(posedge clk); #1;
      a = a0 + 32'(k * 4);
      m_sel = 1; m_seq = 1; m_addr = a; m_be = 4'($urandom); m_wdata = $urandom;
      @(negedge clk);
      if (k == 0) begin
        exp_ack = f_hit(a) && a[1:0] == 2'b00;
        chk(!f_hit(a) ? "R1 burst decode" : (a[1:0] != 0 ? "R4 misaligned start" : "R3 burst start"),
            s_ack, exp_ack);
        if (!exp_ack) break;
        hi = f_hi(a);
      end else if (cnt == 16) begin
        chk("R5 beat after 16 words", {s_retry, s_ack}, 2'b10);
        break;
      end else begin
        exp_ack = (a <= hi);
        chk(exp_ack ? "R3 burst beat" : "R6 beat past range end", s_ack, exp_ack);
        if (!exp_ack) break;
      end
      exp_mem[cnt] = m_wdata;
      cnt++;
    end
    @(posedge clk); #1;
    m_sel = 0; m_seq = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R3 request after burst", dn_req, cnt > 0);
    if (cnt > 0) begin
      chk("R3 burst kind", dn_burst, 1'b1);
      chk(cnt == 1 ? "R9 one-word burst length" : (cnt == 16 ? "R5 capped length" : "R3 burst length"),
          32'(dn_len), 32'(cnt));
      chk("R3 burst enables", dn_be, 4'hF);
      chk("R3 burst address", dn_addr, a0[31:2]);
      check_buf(cnt);
      finish_req(collide);
    end
  endtask

  initial begin
    #2_000_000;
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    end
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk("R10 reset request", dn_req, 1'b0);
    chk("R10 reset length", dn_len, 5'd0);
    for (int i = 0; i < 16; i++) begin
      rd_idx = 4'(i); #1;
      chk("R10 reset buffer", rd_data, 32'd0);
    end

    single(HI0 - 3, 4'b0101, 32'hCAFE_0001, 0);
    single(LO1, 4'b1000, 32'hCAFE_0002, 1);
    single(32'h2000_0000, 4'hF, 32'hDEAD_0000, 0);
    single(LO0 - 1, 4'hF, 32'hDEAD_0001, 0);
    burst(LO0, 20, 1);
    burst(HI0 - 11, 6, 0);
    burst(LO0 + 2, 4, 0);
    burst(LO1 + 32'h40, 1, 1);
    burst(HI1 - 3, 3, 0);

    for (int it = 0; it < 80; it++) begin
      logic [31:0] base, a;
      base = ($urandom % 2) ? LO1 : LO0;
      a = base + 32'(($urandom % 64) * 4);
      if ($urandom % 8 == 0) a = a + 32'($urandom % 4);
      if ($urandom % 10 == 0) a = 32'h3000_0000 + 32'(($urandom % 16) * 4);
      if ($urandom % 3 == 0)
        single(a, 4'($urandom), $urandom, 1'($urandom));
      else
        burst(a, 1 + int'($urandom % 20), 1'($urandom));
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule